// File: doc/BRIEF.md
# Multiply-Accumulate Register Peripheral

A bus-attached 16x16 multiplier with a 32-bit accumulator, reached through eight word registers on a simple synchronous read/write port. Software picks the operation by choosing which of four first-operand slots it writes. That choice sets a hidden two-bit mode: signed or unsigned, and replace or accumulate. The mode cannot be read back.

Each write to the second-operand register launches one operation under the last recorded mode. The product either overwrites the 32-bit result pair or is added to it. A read-only extension word reports the carry, or the sign, of the outcome. Results land a fixed three cycles after the launching write, and a busy output covers that window. Software may preload the result pair before accumulating.

Register index map on `addr_i`:
- 0: unsigned multiply, first operand.
- 1: signed multiply, first operand.
- 2: unsigned accumulate, first operand.
- 3: signed accumulate, first operand.
- 4: second operand.
- 5: result bits 15:0.
- 6: result bits 31:16.
- 7: extension word.

For indices 0 to 3, bit 0 of the index means signed and bit 1 means accumulate.

Top module: `mac_periph`

## Requirements
- R1: After reset, every one of the eight registers reads 0x0000 and `busy_o` is low.
- R2: A write to any of indices 0 to 3 stores the value. Reads of all four indices return that same value, whichever slot was written.
- R3: The index of the last first-operand write selects the mode: bit 0 means signed, bit 1 means accumulate. Every later operand-2 write reuses that mode until another first-operand write.
- R4: A multiply mode puts the 32-bit product into the result pair. Unsigned modes treat both operands as unsigned. Signed modes treat them as two's complement.
- R5: An accumulate mode adds the product to the result pair as it stood at the commit edge. Indices 5 and 6 are writable to preload that pair.
- R6: The extension word is set at each commit as follows:
  - unsigned multiply: 0.
  - signed multiply: the sign extension of the product.
  - unsigned accumulate: the carry out of the 32-bit sum (0 or 1).
  - signed accumulate: the sign extension of the 32-bit sum (0x0000 or 0xFFFF).
  
  A write to index 7 has no effect.
- R7: A result is committed on the third rising edge after the operand-2 write edge. Reads before that commit return the previous contents.
- R8: `busy_o` is high for exactly the three cycles between the launching write edge and the commit edge.
- R9: An operand-2 write while an operation is in flight restarts the latency count with the new operand. The earlier operation never commits.
- R10: Reset leaves the hidden mode at unsigned multiply.
- R11: Index 4 reads back the last value written to it.
- R12: When a software write to index 5 or 6 and a commit fall on the same edge, the commit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 3 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| busy_o | output | 1 | Operation in flight |

## Verification
Read data is combinational on the current index, so a register write is visible on the cycle after its edge. A commit becomes visible on the fourth cycle after the operand-2 write: the three cycles in between must still show the old result. `busy_o` must rise the cycle after that write and fall the cycle after the commit edge. The bench's behavioural model counts these cycles down from each launch. It compares read data and busy on every cycle, just before the rising edge, so a result that arrives early or late shows up as a mismatch.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    IDX_MPYU = 3'd0,
    IDX_MPYS = 3'd1,
    IDX_MACU = 3'd2,
    IDX_MACS = 3'd3,
    IDX_OPB  = 3'd4,
    IDX_RLO  = 3'd5,
    IDX_RHI  = 3'd6,
    IDX_EXT  = 3'd7
  } reg_idx_e;

  // packed order matches index bits [1:0]
  typedef struct packed {
    logic acc;
    logic sgn;
  } mode_t;

  localparam mode_t MODE_RST = '{acc: 1'b0, sgn: 1'b0};
endpackage

// File: rtl/mac_opreg.sv
module mac_opreg
  import mac_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op1_we_i,
  input  logic          op2_we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] op1_o,
  output logic [DW-1:0] op2_o,
  output mode_t         mode_o
);
  logic [DW-1:0] op1_q, op2_q;
  mode_t         mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op1_q  <= '0;
      op2_q  <= '0;
      mode_q <= MODE_RST;
    end else begin
      if (op1_we_i) begin
        op1_q  <= wdata_i;
        mode_q <= mode_t'(sel_i);
      end
      if (op2_we_i) op2_q <= wdata_i;
    end
  end

  assign op1_o  = op1_q;
  assign op2_o  = op2_q;
  assign mode_o = mode_q;

  // R2
  op1_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op1_we_i |=> op1_o == $past(wdata_i));
  // R3
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op1_we_i |=> $stable(mode_o));
endmodule

// File: rtl/mac_mul_pipe.sv
module mac_mul_pipe
  import mac_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned LAT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  mode_t           mode_i,
  output logic [2*DW-1:0] prod_o,
  output mode_t           mode_o,
  output logic            commit_o,
  output logic            busy_o
);
  localparam int unsigned PW = 2 * DW;
  localparam int unsigned XW = DW + 1;

  logic [DW-1:0]  s_a_q, s_b_q;
  mode_t          s_mode_q;
  logic [LAT-1:0] v_q;
  logic [PW-1:0]  prod_q;

  logic signed [XW-1:0]   ax, bx;
  logic signed [2*XW-1:0] full;

  always_comb begin
    ax   = {s_mode_q.sgn & s_a_q[DW-1], s_a_q};
    bx   = {s_mode_q.sgn & s_b_q[DW-1], s_b_q};
    full = ax * bx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_a_q    <= '0;
      s_b_q    <= '0;
      s_mode_q <= MODE_RST;
      v_q      <= '0;
      prod_q   <= '0;
    end else begin
      if (start_i) begin
        s_a_q    <= a_i;
        s_b_q    <= b_i;
        s_mode_q <= mode_i;
        v_q      <= LAT'(1);
      end else begin
        v_q <= v_q << 1;
      end
      if (v_q[0]) prod_q <= full[PW-1:0];
    end
  end

  assign prod_o   = prod_q;
  assign mode_o   = s_mode_q;
  assign commit_o = v_q[LAT-1];
  assign busy_o   = |v_q;

  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R9
  single_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> $countones(v_q) == 1 && !commit_o);
  // R8
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o && !start_i |=> !busy_o);
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  logic [2*DW-1:0] prod_i,
  input  mode_t           mode_i,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [2*DW-1:0] res_o,
  output logic [DW-1:0]   ext_o
);
  localparam int unsigned PW = 2 * DW;

  logic [PW-1:0] res_q, res_d;
  logic [DW-1:0] ext_q, ext_d;
  logic [PW:0]   sum;

  always_comb begin
    sum = {1'b0, res_q} + {1'b0, prod_i};
    if (mode_i.acc) begin
      res_d = sum[PW-1:0];
      ext_d = mode_i.sgn ? {DW{sum[PW-1]}} : DW'(sum[PW]);
    end else begin
      res_d = prod_i;
      ext_d = mode_i.sgn ? {DW{prod_i[PW-1]}} : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ext_q <= '0;
    end else if (commit_i) begin
      res_q <= res_d;
      ext_q <= ext_d;
    end else begin
      if (lo_we_i) res_q[DW-1:0]  <= wdata_i;
      if (hi_we_i) res_q[PW-1:DW] <= wdata_i;
    end
  end

  assign res_o = res_q;
  assign ext_o = ext_q;

  // R6
  ext_umpy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !mode_i.acc && !mode_i.sgn |=> ext_o == '0);
  // R6
  ext_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && mode_i.sgn |=> ext_o == {DW{res_o[PW-1]}});
  // R6
  ext_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && mode_i.acc && !mode_i.sgn |=> ext_o <= DW'(1));
  // R7
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i && !lo_we_i && !hi_we_i |=> $stable(res_o) && $stable(ext_o));
endmodule

// File: rtl/mac_periph.sv
module mac_periph
  import mac_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              busy_o
);
  localparam int unsigned PW = 2 * DW;

  logic          op1_we, op2_we, lo_we, hi_we;
  logic [DW-1:0] op1, op2, ext;
  logic [PW-1:0] prod, res;
  mode_t         cur_mode, pipe_mode;
  logic          commit;

  assign op1_we = wr_en_i && (addr_i[REG_AW-1] == 1'b0);
  assign op2_we = wr_en_i && (addr_i == IDX_OPB);
  assign lo_we  = wr_en_i && (addr_i == IDX_RLO);
  assign hi_we  = wr_en_i && (addr_i == IDX_RHI);

  mac_opreg #(.DW(DW)) u_opreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op1_we_i (op1_we),
    .op2_we_i (op2_we),
    .sel_i    (addr_i[1:0]),
    .wdata_i  (wdata_i),
    .op1_o    (op1),
    .op2_o    (op2),
    .mode_o   (cur_mode)
  );

  mac_mul_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (op2_we),
    .a_i      (op1),
    .b_i      (wdata_i),
    .mode_i   (cur_mode),
    .prod_o   (prod),
    .mode_o   (pipe_mode),
    .commit_o (commit),
    .busy_o   (busy_o)
  );

  mac_accum #(.DW(DW)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .prod_i   (prod),
    .mode_i   (pipe_mode),
    .lo_we_i  (lo_we),
    .hi_we_i  (hi_we),
    .wdata_i  (wdata_i),
    .res_o    (res),
    .ext_o    (ext)
  );

  always_comb begin
    unique case (addr_i)
      IDX_MPYU, IDX_MPYS, IDX_MACU, IDX_MACS: rdata_o = op1;
      IDX_OPB: rdata_o = op2;
      IDX_RLO: rdata_o = res[DW-1:0];
      IDX_RHI: rdata_o = res[PW-1:DW];
      default: rdata_o = ext;
    endcase
  end

  // R12
  commit_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && pipe_mode == MODE_RST |=> res == $past(prod));
  // R11
  opb_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op2_we |=> addr_i != IDX_OPB || rdata_o == $past(wdata_i));
endmodule

// File: tb/mac_periph_tb.sv
`timescale 1ns/1ps
module mac_periph_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mac_periph dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .busy_o  (busy)
  );

  // behavioural model
  logic [15:0] m_op1, m_op2, m_ext;
  logic [31:0] m_res;
  logic [1:0]  m_mode;
  int          m_cnt;
  logic [15:0] p_a, p_b;
  logic [1:0]  p_mode;

  task automatic model_reset();
    m_op1 = 0; m_op2 = 0; m_ext = 0; m_res = 0; m_mode = 0; m_cnt = 0;
    p_a = 0; p_b = 0; p_mode = 0;
  endtask

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2, 3'd3: return m_op1;
      3'd4: return m_op2;
      3'd5: return m_res[15:0];
      3'd6: return m_res[31:16];
      default: return m_ext;
    endcase
  endfunction

  task automatic model_edge(input logic we, input logic [2:0] a, input logic [15:0] d);
    logic        do_commit;
    longint      prod_l;
    logic [31:0] prod;
    logic [32:0] sum;
    logic [31:0] old_res;
    do_commit = (m_cnt == 1);
    old_res = m_res;
    if (we) begin
      if (a < 3'd4) begin m_op1 = d; m_mode = a[1:0]; end
      if (a == 3'd5) m_res[15:0] = d;
      if (a == 3'd6) m_res[31:16] = d;
    end
    if (do_commit) begin
      if (p_mode[0]) prod_l = longint'($signed(p_a)) * longint'($signed(p_b));
      else prod_l = longint'(p_a) * longint'(p_b);
      prod = prod_l[31:0];
      if (p_mode[1]) begin
        sum = {1'b0, old_res} + {1'b0, prod};
        m_res = sum[31:0];
        m_ext = p_mode[0] ? {16{sum[31]}} : {15'd0, sum[32]};
      end else begin
        m_res = prod;
        m_ext = p_mode[0] ? {16{prod[31]}} : 16'h0;
      end
    end
    if (we && a == 3'd4) begin
      p_a = m_op1; p_b = d; p_mode = m_mode; m_op2 = d; m_cnt = 3;
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
    end
  endtask

  task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d, input string req);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    #1;
    check16(rdata, model_read(a), req);
    check16({15'd0, busy}, {15'd0, m_cnt > 0}, "R8 busy");
    @(posedge clk);
    model_edge(we, a, d);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string req);
    step(1'b1, a, d, req);
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    step(1'b0, a, 16'h0, req);
  endtask

  // read with a literal expectation in addition to the model
  task automatic rd_exp(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    wr_en = 1'b0; addr = a; wdata = 16'h0;
    #1;
    check16(rdata, exp, req);
    check16(rdata, model_read(a), req);
    @(posedge clk);
    model_edge(1'b0, a, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) rd_exp(3'(i), 16'h0, "R1 reset value");

    // R10 default mode is unsigned multiply: preload is overwritten, not added
    wr(3'd5, 16'h1234, "R5 preload lo");
    wr(3'd4, 16'h0005, "R10 launch");
    rd_exp(3'd5, 16'h1234, "R7 old value during latency");
    rd_exp(3'd5, 16'h1234, "R7 old value during latency");
    rd_exp(3'd5, 16'h1234, "R7 old value during latency");
    rd_exp(3'd5, 16'h0000, "R10 multiply overwrote preload");

    // R4 unsigned
    wr(3'd0, 16'hFFFF, "R2 op1 write");
    wr(3'd4, 16'hFFFF, "R4 launch");
    for (int i = 0; i < 3; i++) rd(3'd6, "R7 wait");
    rd_exp(3'd5, 16'h0001, "R4 unsigned lo");
    rd_exp(3'd6, 16'hFFFE, "R4 unsigned hi");
    rd_exp(3'd7, 16'h0000, "R6 unsigned multiply ext");

    // R3 unsigned vs signed with the same operands
    wr(3'd4, 16'h0002, "R3 reuse unsigned mode");
    for (int i = 0; i < 3; i++) rd(3'd5, "R7 wait");
    rd_exp(3'd6, 16'h0001, "R3 unsigned hi");
    wr(3'd1, 16'hFFFF, "R3 select signed");
    wr(3'd4, 16'h0002, "R4 launch signed");
    for (int i = 0; i < 3; i++) rd(3'd5, "R7 wait");
    rd_exp(3'd5, 16'hFFFE, "R4 signed lo");
    rd_exp(3'd6, 16'hFFFF, "R4 signed hi");
    rd_exp(3'd7, 16'hFFFF, "R6 signed multiply ext");

    // R2 all op1 slots read back the same value
    wr(3'd1, 16'hABCD, "R2 write signed slot");
    for (int i = 0; i < 4; i++) rd_exp(3'(i), 16'hABCD, "R2 op1 alias read");

    // R5 unsigned accumulate with carry
    wr(3'd5, 16'hFFFF, "R5 preload lo");
    wr(3'd6, 16'hFFFF, "R5 preload hi");
    wr(3'd2, 16'h0001, "R3 select unsigned acc");
    wr(3'd4, 16'h0001, "R5 launch");
    for (int i = 0; i < 3; i++) rd(3'd7, "R7 wait");
    rd_exp(3'd5, 16'h0000, "R5 acc wrap lo");
    rd_exp(3'd6, 16'h0000, "R5 acc wrap hi");
    rd_exp(3'd7, 16'h0001, "R6 acc carry");

    // R5 signed accumulate twice
    wr(3'd5, 16'h0005, "R5 preload lo");
    wr(3'd6, 16'h0000, "R5 preload hi");
    wr(3'd3, 16'hFFFD, "R3 select signed acc");
    wr(3'd4, 16'h0004, "R5 launch");
    for (int i = 0; i < 3; i++) rd(3'd5, "R7 wait");
    rd_exp(3'd5, 16'hFFF9, "R5 signed acc lo");
    rd_exp(3'd7, 16'hFFFF, "R6 signed acc ext");
    wr(3'd4, 16'h0004, "R3 mode kept");
    for (int i = 0; i < 3; i++) rd(3'd5, "R7 wait");
    rd_exp(3'd5, 16'hFFED, "R5 second acc lo");
    rd_exp(3'd6, 16'hFFFF, "R5 second acc hi");

    // R6 extension word is read-only
    wr(3'd7, 16'h1234, "R6 ext write");
    rd_exp(3'd7, 16'hFFFF, "R6 ext unchanged");

    // R9 restart discards the first operation
    wr(3'd0, 16'h0003, "R9 select");
    wr(3'd4, 16'h0007, "R9 first launch");
    rd(3'd5, "R9 wait");
    wr(3'd4, 16'h0009, "R9 restart");
    rd_exp(3'd5, 16'hFFED, "R9 no early commit");
    rd_exp(3'd5, 16'hFFED, "R9 no early commit");
    rd_exp(3'd5, 16'hFFED, "R9 no early commit");
    rd_exp(3'd5, 16'h001B, "R9 restarted result");
    rd_exp(3'd4, 16'h0009, "R11 op2 readback");

    // R12 commit beats a same-edge software write
    wr(3'd0, 16'h0002, "R12 select");
    wr(3'd4, 16'h0003, "R12 launch");
    rd(3'd5, "R12 wait");
    rd(3'd5, "R12 wait");
    wr(3'd5, 16'h5555, "R12 colliding write");
    rd_exp(3'd5, 16'h0006, "R12 commit wins");

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      step(1'($urandom_range(0, 1)), a, 16'($urandom), "R3 R4 R5 R6 mixed");
    end

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule